// File: doc/BRIEF.md
# Parallel Tuning Register Write Port

This block is the host-facing load path of a numerically controlled oscillator. It holds two frequency tuning words and four phase offset words and drives them out as parallel buses toward the accumulator and phase adder. A processor writes 16 bits at a time over a parallel data bus. It uses a 3-bit address and an active-low write strobe. The address and the data are taken in on the rising edge of the strobe. The word then crosses into the master clock domain and is applied to its destination on a master clock edge.

The strobe is treated as a clock of its own. Each write fills one slot of a small ring of capture slots and flips that slot's flag. The flag passes through a synchronizer of `SYNC_STAGES` flops into the master clock domain. A read pointer in the master domain applies the slots strictly in arrival order, at most one per master cycle. A slot's captured address and data are never overwritten before they have been applied, so the processor may write once per master cycle with no loss.

The reset input only clears the handshake state. The tuning and phase words keep their contents through reset. At power-up their contents are unknown until software loads them.

Top module: `tuning_write_port`

## Requirements
- R1: Address decode: 000 loads bits 15:0 of frequency word 0; 001 loads bits 31:16 of frequency word 0; 010 and 011 do the same for frequency word 1; 100, 101, 110 and 111 load phase words 0, 1, 2 and 3.
- R2: A write changes only the register it addresses. Every other output bus keeps its value.
- R3: A write becomes visible on the outputs at exactly the (SYNC_STAGES+1)-th master clock rising edge after the strobe's rising edge, and never earlier. This holds whether the strobe rises in the first half or the second half of the master clock period.
- R4: A phase word takes data bits 11:0. Data bits 15:12 have no effect on any output.
- R5: Each half of a frequency word is loaded on its own. Writing one half leaves the other half unchanged.
- R6: Asserting rst_n (low) does not change any frequency or phase output.
- R7: Only the address and data present at the strobe's rising edge count. Values driven on the buses after that edge do not alter the result.
- R8: Writes issued once per master clock cycle, to any mix of addresses, all land in order, with none lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset of the handshake state only |
| wr_n | input | 1 | Active-low write strobe; its rising edge captures address and data |
| addr | input | ADDR_W (3) | Destination register select |
| data | input | DATA_W (16) | Write data |
| freq0_o | output | FREQ_W (32) | Frequency tuning word 0 |
| freq1_o | output | FREQ_W (32) | Frequency tuning word 1 |
| phase0_o | output | PHASE_W (12) | Phase offset word 0 |
| phase1_o | output | PHASE_W (12) | Phase offset word 1 |
| phase2_o | output | PHASE_W (12) | Phase offset word 2 |
| phase3_o | output | PHASE_W (12) | Phase offset word 3 |

## Verification
The bench builds the block with SYNC_STAGES set to 1. This gives the shortest commit window of two master edges. It also gives a three-slot ring, whose pointers wrap at a count that is not a power of two. Under that setting, a run of one write per cycle keeps every slot busy and drives both pointers through many wraps. Strobe rises placed before and after the falling clock edge test that the commit cycle does not depend on where the strobe falls in the period.

// File: rtl/tuning_write_port.sv
module tuning_write_port #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int FREQ_W      = 32,
  parameter int PHASE_W     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o,
  output logic [PHASE_W-1:0] phase2_o,
  output logic [PHASE_W-1:0] phase3_o
);
  localparam int HALF  = FREQ_W / 2;
  localparam int DEPTH = SYNC_STAGES + 2;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // strobe domain: capture ring
  logic [PTR_W-1:0]  wp;
  logic [DEPTH-1:0]  tog;
  logic [ADDR_W-1:0] cap_a [DEPTH];
  logic [DATA_W-1:0] cap_d [DEPTH];

  always_ff @(posedge wr_n or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      tog <= '0;
    end else begin
      tog[wp] <= ~tog[wp];
      wp      <= (wp == LAST) ? '0 : wp + 1'b1;
    end

  always_ff @(posedge wr_n) begin
    cap_a[wp] <= addr;
    cap_d[wp] <= data;
  end

  // master domain: synchronise flags, drain in order
  logic [DEPTH-1:0][SYNC_STAGES-1:0] sync_q;
  logic [DEPTH-1:0] synced, seen;
  logic [PTR_W-1:0] rp;
  logic             commit;
  logic [ADDR_W-1:0] c_a;
  logic [DATA_W-1:0] c_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else
      for (int i = 0; i < DEPTH; i++)
        sync_q[i] <= (sync_q[i] << 1) | SYNC_STAGES'(tog[i]);

  always_comb
    for (int i = 0; i < DEPTH; i++) synced[i] = sync_q[i][SYNC_STAGES-1];

  assign commit = synced[rp] != seen[rp];
  assign c_a    = cap_a[rp];
  assign c_d    = cap_d[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen <= '0;
      rp   <= '0;
    end else if (commit) begin
      seen[rp] <= ~seen[rp];
      rp       <= (rp == LAST) ? '0 : rp + 1'b1;
    end

  // tuning registers: never reset
  logic [FREQ_W-1:0]  freq_q  [2];
  logic [PHASE_W-1:0] phase_q [4];

  always_ff @(posedge clk)
    if (commit) begin
      if (!c_a[2]) begin
        if (c_a[0]) freq_q[c_a[1]][FREQ_W-1:HALF] <= c_d[HALF-1:0];
        else        freq_q[c_a[1]][HALF-1:0]      <= c_d[HALF-1:0];
      end else begin
        phase_q[c_a[1:0]] <= c_d[PHASE_W-1:0];
      end
    end

  assign freq0_o  = freq_q[0];
  assign freq1_o  = freq_q[1];
  assign phase0_o = phase_q[0];
  assign phase1_o = phase_q[1];
  assign phase2_o = phase_q[2];
  assign phase3_o = phase_q[3];

  // assertions
  p_hold_without_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (freq0_o === $past(freq0_o)) && (freq1_o === $past(freq1_o)) &&
                (phase0_o === $past(phase0_o)) && (phase3_o === $past(phase3_o)));

  p_low_half_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit && c_a == 3'b000 |=> freq0_o[FREQ_W-1:HALF] === $past(freq0_o[FREQ_W-1:HALF]));

  p_high_half_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit && c_a == 3'b011 |=> freq1_o[HALF-1:0] === $past(freq1_o[HALF-1:0]));

  p_other_word_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit && c_a[2:1] == 2'b00 |=> freq1_o === $past(freq1_o));

  p_phase_quiet_on_freq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !c_a[2] |=> (phase1_o === $past(phase1_o)) && (phase2_o === $past(phase2_o)));

  p_phase_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && c_a == 3'b110 |=> phase2_o === $past(c_d[PHASE_W-1:0]));
endmodule

// File: tb/tuning_write_port_test.sv
`timescale 1ns/100ps
module tuning_write_port_test;
  localparam int S = 1;

  logic        clk = 1'b0, rst_n = 1'b0, wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] data = '0;
  logic [31:0] f0, f1;
  logic [11:0] p0, p1, p2, p3;

  tuning_write_port #(.SYNC_STAGES(S)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data),
    .freq0_o(f0), .freq1_o(f1),
    .phase0_o(p0), .phase1_o(p1), .phase2_o(p2), .phase3_o(p3));

  always #2.5 clk = ~clk;

  typedef struct { int due; logic [2:0] a; logic [15:0] d; } wr_t;
  wr_t pend[$];
  logic [31:0] mf [2];
  logic [11:0] mp [4];
  int edge_cnt = 0, n_cmp = 0, n_bad = 0;
  bit checking = 0, done = 0;
  string cur_req = "R6";

  always @(posedge clk) edge_cnt++;

  task automatic apply(wr_t w);
    if (w.a[2]) mp[w.a[1:0]] = w.d[11:0];
    else if (w.a[0]) mf[w.a[1]][31:16] = w.d;
    else mf[w.a[1]][15:0] = w.d;
  endtask

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at edge %0d", cur_req, what, act, exp, edge_cnt);
    end
  endtask

  always @(negedge clk) if (checking && !done) begin
    while (pend.size() > 0 && pend[0].due <= edge_cnt) apply(pend.pop_front());
    cmp("freq0", f0, mf[0]);
    cmp("freq1", f1, mf[1]);
    cmp("phase0", {20'd0, p0}, {20'd0, mp[0]});
    cmp("phase1", {20'd0, p1}, {20'd0, mp[1]});
    cmp("phase2", {20'd0, p2}, {20'd0, mp[2]});
    cmp("phase3", {20'd0, p3}, {20'd0, mp[3]});
  end

  task automatic do_wr(logic [2:0] a, logic [15:0] d, bit late);
    wr_t w;
    @(posedge clk);
    #0.5 addr = a; data = d; wr_n = 1'b0;
    if (late) #3.0; else #0.7;
    wr_n = 1'b1;
    w.due = edge_cnt + S + 1; w.a = a; w.d = d;
    pend.push_back(w);
    #0.3 addr = ~a; data = ~d;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    checking = 1;
    cur_req = "R1/R2";
    for (int a = 0; a < 8; a++) do_wr(3'(a), 16'(16'h1357 * (a + 3)), a[0]);
    idle(4);
    cur_req = "R5";
    do_wr(3'b000, 16'hAAAA, 0); idle(3);
    do_wr(3'b001, 16'h5555, 1); idle(3);
    do_wr(3'b011, 16'hC0DE, 0); idle(3);
    cur_req = "R4";
    do_wr(3'b100, 16'hF123, 0); idle(3);
    do_wr(3'b111, 16'hBFFF, 1); idle(3);
    cur_req = "R6";
    rst_n = 1'b0; idle(3);
    #1 rst_n = 1'b1; idle(2);
    cur_req = "R3";
    for (int k = 0; k < 16; k++) begin
      do_wr(3'(k), 16'(k * 977 + 5), k[1]);
      idle(k % 3);
    end
    idle(4);
    cur_req = "R7";
    do_wr(3'b101, 16'h0ABC, 1); idle(3);
    do_wr(3'b010, 16'h7E7E, 0); idle(3);
    cur_req = "R8";
    for (int k = 0; k < 60; k++) begin
      seed = seed * 1103515245 + 12345;
      do_wr(3'(seed >>> 16), 16'(seed >>> 8), seed[20]);
    end
    idle(6);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule